// File: doc/BRIEF.md
# Byte-Stream Accumulator Processor

This block is a very small 8-bit processor built around a single accumulator. It reads its program one byte at a time from a synchronous memory, using a 16-bit address and an 8-bit read data bus. Every instruction passes through three phases: fetch, decode and execute. Two instructions carry an immediate operand in the byte after the opcode. One of them sets the accumulator to that byte. The other adds that byte to the accumulator, and the carry out of that addition is held in a one-bit flag. A third opcode, and every opcode the core does not know, stops the core for good until the next reset.

The address output always shows the program counter. The program counter moves forward by one each time the core takes a byte from memory, so the opcode byte, the operand byte and the stopping byte each advance it. Memory returns data one clock after the cycle in which the read strobe and the address were presented. The accumulator, the carry flag and a stopped indication are brought out so the surrounding logic can observe them.

Top module: `acc_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the address is 1400h, the read strobe is 1, the accumulator is 00h, carry is 0 and halted is 0.
- R2: Opcode B0h followed by byte V sets the accumulator to V.
- R3: Opcode 04h followed by byte V sets the accumulator to (A + V) mod 256, and sets carry to the ninth bit of that sum.
- R4: A load (B0h) leaves the carry flag unchanged.
- R5: Opcode 00h stops the core. After that, halted is 1, the read strobe stays 0, and the address, accumulator and carry do not change.
- R6: The program counter drives the address. It increases by one after every byte read, including operand and stopping bytes. For the program B0 21 04 42 04 12 00 placed at 1400h, the core finishes with accumulator 75h and address 1407h.
- R7: Any opcode other than B0h, 04h or 00h acts as a stop, and the byte after it is never read.
- R8: Read data is taken one clock after the strobe. A two-byte instruction takes 4 cycles and a stop takes 2 cycles. The strobe is high in only one cycle per byte and is never high in two cycles in a row.
- R9: Asserting reset at any time brings the core back to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Byte address, equal to the program counter |
| mem_rd | output | 1 | Read request for the byte at mem_addr |
| mem_data | input | 8 | Read data, valid one cycle after mem_rd |
| halted | output | 1 | High once a stop opcode has been decoded |
| acc | output | 8 | Accumulator value |
| carry | output | 1 | Carry out of the most recent add |

## Verification
Two updates can land on the same clock edge: the accumulator wrapping past FFh, and the carry flag capturing the ninth bit of the sum. Programs that add 01h to FFh, and F0h plus 20h, force both updates onto one edge. The bench then reads the zero or low result together with carry set. A following add that does not overflow must clear carry on the same edge that writes its sum. A load placed between these adds must change the accumulator and leave carry alone.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] OPC_LOAD = 8'hB0;
    localparam logic [DATA_W-1:0] OPC_ADD  = 8'h04;
    localparam logic [DATA_W-1:0] OPC_STOP = 8'h00;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_DECODE,
        PH_OPRD,
        PH_EXEC,
        PH_HALT
    } phase_t;

    typedef enum logic [1:0] {
        K_LOAD,
        K_ADD,
        K_STOP
    } op_kind_t;

    typedef struct packed {
        logic              cy;
        logic [DATA_W-1:0] a;
    } acc_state_t;

    function automatic op_kind_t classify(input logic [DATA_W-1:0] b);
        case (b)
            OPC_LOAD: classify = K_LOAD;
            OPC_ADD:  classify = K_ADD;
            default:  classify = K_STOP;
        endcase
    endfunction

    function automatic acc_state_t add_wide(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y);
        logic [DATA_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        add_wide.cy = s[DATA_W];
        add_wide.a  = s[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rd,
    output logic              load_en,
    output logic              add_en,
    output logic              stopped
);

    phase_t   phase;
    op_kind_t kind;
    op_kind_t dec;

    assign dec = classify(mem_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            kind  <= K_STOP;
        end else begin
            case (phase)
                PH_FETCH:  phase <= PH_DECODE;
                PH_DECODE: begin
                    kind  <= dec;
                    phase <= (dec == K_STOP) ? PH_HALT : PH_OPRD;
                end
                PH_OPRD:   phase <= PH_EXEC;
                PH_EXEC:   phase <= PH_FETCH;
                default:   phase <= PH_HALT;
            endcase
        end
    end

    assign rd      = (phase == PH_FETCH) || (phase == PH_OPRD);
    assign load_en = (phase == PH_EXEC) && (kind == K_LOAD);
    assign add_en  = (phase == PH_EXEC) && (kind == K_ADD);
    assign stopped = (phase == PH_HALT);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd |=> !rd) else $error("strobe high twice");                    // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        stopped |=> stopped) else $error("halt released");               // R5
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !rd) else $error("read while halted");               // R5

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h1400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] ONE = 1;

    always_ff @(posedge clk) begin
        if (rst)       pc <= RESET_PC;
        else if (step) pc <= pc + ONE;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> pc == $past(pc) + ONE) else $error("pc step");         // R6
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc)) else $error("pc moved");                 // R6

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              add_en,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc,
    output logic              carry
);

    acc_state_t st;
    acc_state_t sum;

    assign sum = add_wide(st.a, operand);

    always_ff @(posedge clk) begin
        if (rst)          st <= '0;
        else if (add_en)  st <= sum;
        else if (load_en) st.a <= operand;
    end

    assign acc   = st.a;
    assign carry = st.cy;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load_en |=> acc == $past(operand)) else $error("load");        // R2
    AST_LOAD_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
        load_en |=> $stable(carry)) else $error("carry on load");      // R4
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        add_en |=> {carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)}))
        else $error("add");                                             // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en && !add_en |=> $stable(acc) && $stable(carry))
        else $error("idle change");                                     // R5

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h1400
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_data,
    output logic              halted,
    output logic [DATA_W-1:0] acc,
    output logic              carry
);

    logic load_en;
    logic add_en;

    acc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mem_data (mem_data),
        .rd       (mem_rd),
        .load_en  (load_en),
        .add_en   (add_en),
        .stopped  (halted)
    );

    acc_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .step (mem_rd),
        .pc   (mem_addr)
    );

    acc_alu u_alu (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .add_en  (add_en),
        .operand (mem_data),
        .acc     (acc),
        .carry   (carry)
    );

    AST_EXEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(load_en && add_en) && !(halted && (load_en || add_en)))
        else $error("exec overlap");                                    // R7

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data;
    logic        halted;
    logic [7:0]  acc;
    logic        carry;

    logic [7:0]  rom [256];
    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_data(mem_data), .halted(halted), .acc(acc), .carry(carry)
    );

    always_ff @(posedge clk) begin
        if (mem_rd)
            mem_data <= (mem_addr[15:8] == 8'h14) ? rom[mem_addr[7:0]] : 8'h00;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic run(output int cyc, output int rds);
        cyc = 0; rds = 0;
        while (!halted && cyc < 200) begin
            if (mem_rd) rds++;
            @(posedge clk); cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        clear_rom();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 addr", mem_addr, 32'h1400);
        check("R1 rd", mem_rd, 1);
        check("R1 acc", acc, 0);
        check("R1 carry", carry, 0);
        check("R1 halted", halted, 0);
        rst = 1'b0;
        check("R1 first cycle addr", mem_addr, 32'h1400);
    endtask

    task automatic t_sample_program();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'h21; rom[2]=8'h04; rom[3]=8'h42;
        rom[4]=8'h04; rom[5]=8'h12; rom[6]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R6 final acc", acc, 32'h75);
        check("R6 final addr", mem_addr, 32'h1407);
        check("R3 no carry", carry, 0);
        check("R8 cycles", cyc, 14);
        check("R8 reads", rds, 7);
        check("R5 halted", halted, 1);
    endtask

    task automatic t_load_only();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'hA5; rom[2]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R2 load value", acc, 32'hA5);
        check("R8 load cycles", cyc, 6);
    endtask

    task automatic t_overflow();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'hFF; rom[2]=8'h04; rom[3]=8'h01; rom[4]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R3 wrap acc", acc, 32'h00);
        check("R3 wrap carry", carry, 1);
    endtask

    task automatic t_load_keeps_carry();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'hF0; rom[2]=8'h04; rom[3]=8'h20;
        rom[4]=8'hB0; rom[5]=8'h05; rom[6]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R4 acc after load", acc, 32'h05);
        check("R4 carry kept", carry, 1);
    endtask

    task automatic t_carry_clear();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'hF0; rom[2]=8'h04; rom[3]=8'h20;
        rom[4]=8'h04; rom[5]=8'h01; rom[6]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R3 acc", acc, 32'h11);
        check("R3 carry cleared", carry, 0);
    endtask

    task automatic t_undefined();
        int cyc, rds;
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'h33; rom[2]=8'h7E; rom[3]=8'h04; rom[4]=8'h01;
        do_reset();
        run(cyc, rds);
        check("R7 halted", halted, 1);
        check("R7 acc", acc, 32'h33);
        check("R7 addr", mem_addr, 32'h1403);
        check("R7 reads", rds, 3);
    endtask

    task automatic t_immediate_stop_and_quiet();
        int cyc, rds;
        logic [15:0] a0;
        int bad;
        clear_rom();
        rom[0]=8'h00;
        do_reset();
        run(cyc, rds);
        check("R5 stop cycles", cyc, 2);
        check("R6 stop addr", mem_addr, 32'h1401);
        a0 = mem_addr; bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            if (mem_rd || !halted || mem_addr != a0 || acc != 0) bad++;
        end
        check("R5 quiet after stop", bad, 0);
    endtask

    task automatic t_mid_reset();
        clear_rom();
        rom[0]=8'hB0; rom[1]=8'h21; rom[2]=8'h04; rom[3]=8'h42; rom[4]=8'h00;
        do_reset();
        repeat (5) begin @(posedge clk); @(negedge clk); end
        check("R9 acc before reset", acc, 32'h21);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 addr", mem_addr, 32'h1400);
        check("R9 acc", acc, 0);
        check("R9 rd", mem_rd, 1);
        check("R9 halted", halted, 0);
        rst = 1'b0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_sample_program();
        t_load_only();
        t_overflow();
        t_load_keeps_carry();
        t_carry_clear();
        t_undefined();
        t_immediate_stop_and_quiet();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule